// File: doc/BRIEF.md
# SPI Serial Memory Slave with Write-Enable Latch

This block is an SPI mode-0 slave in front of a 2048-byte byte-addressed memory held in an internal register file. A bus master lowers chip select and sends an 8-bit command. Depending on the command, the master then sends or receives one status byte, or sends a two-byte address followed by any number of data bytes. Every byte on the wire is most significant bit first. The slave samples its serial input on the rising edge of the serial clock and changes its serial output after the falling edge.

The serial pins are oversampled in the system clock domain. Chip select, serial clock and serial data pass through a synchronizer, and the edges of the serial clock are detected as single-cycle events. All writes are guarded by a write-enable latch. One command sets the latch and another clears it. The latch also clears itself when a command that actually wrote something ends with chip select going high.

The status byte holds the latch at bit 1, three user bits at positions 7, 3 and 2, and zeros everywhere else. The memory address auto-increments after every data byte and wraps at the top of the array.

Top module: `spi_mem_slave`

## Requirements
- R1: After reset the write-enable latch is clear, the status byte reads 0x00, and the serial output is low while chip select is high.
- R2: Command 0x06 sets the write-enable latch, which reads back as status bit 1 (status 0x02 when the other bits are zero).
- R3: Command 0x04 clears the write-enable latch, and a following status read shows bit 1 as 0.
- R4: Command 0x01 with the latch set loads status bits 7, 3 and 2 from the single data byte. Bits 6:4 and 0 always read 0, and data bit 1 does not change the latch. The status therefore reads data AND 0x8C. The latch clears when chip select rises.
- R5: Command 0x01 received while the latch is clear leaves the status unchanged.
- R6: Command 0x02 with the latch set takes a two-byte address (high byte first) and stores each following data byte at consecutive addresses. When chip select rises after at least one data byte, the latch clears.
- R7: Command 0x02 received while the latch is clear writes nothing; memory contents are unchanged.
- R8: Command 0x03 takes a two-byte address and returns the stored bytes MSB first. Each bit is valid before the rising clock edge on which the master samples it. The address increments after every byte and wraps from 0x7FF to 0x000.
- R9: The upper 5 bits of the 16-bit address are ignored: address 0xF800|a selects location a.
- R10: An unknown command byte is ignored together with every byte after it until chip select rises. The serial output stays low and the latch keeps its value.
- R11: A write command that ends after its address bytes, with no data byte, leaves the latch set.
- R12: Command 0x05 returns the status byte, repeated on each further byte. Commands 0x06 and 0x04 ignore any byte that follows them in the same selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master, idles low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master |

## Verification
A wrong latch value shows up at the next status read, or as a memory or status write that is wrongly accepted or refused. Such a write becomes visible with the next read command, within one selection of the bus. A bad address pointer shows up as misplaced bytes on the first read burst that crosses it, in particular around the 0x7FF wrap and at addresses that carry upper bits. A shift or bit-count slip corrupts the very next byte on the serial output, because every returned byte is compared against a value the bench computes arithmetically.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;

    localparam int unsigned BYTE_W = 8;

    localparam logic [7:0] CMD_LATCH_ON  = 8'h06;
    localparam logic [7:0] CMD_LATCH_OFF = 8'h04;
    localparam logic [7:0] CMD_STAT_GET  = 8'h05;
    localparam logic [7:0] CMD_STAT_PUT  = 8'h01;
    localparam logic [7:0] CMD_MEM_GET   = 8'h03;
    localparam logic [7:0] CMD_MEM_PUT   = 8'h02;

    localparam logic [7:0] STAT_USER_MASK = 8'h8C;
    localparam int unsigned STAT_LATCH_POS = 1;

    typedef enum logic [3:0] {
        PH_OPCODE,
        PH_ADDR_HI,
        PH_ADDR_LO,
        PH_MEM_GET,
        PH_MEM_PUT,
        PH_STAT_GET,
        PH_STAT_PUT,
        PH_DISCARD
    } phase_e;

    typedef struct packed {
        logic sck_rise;
        logic sck_fall;
        logic selected;
        logic released;
        logic mosi;
    } pin_evt_t;

    typedef struct packed {
        logic             valid;
        logic [BYTE_W-1:0] data;
    } rx_byte_t;

    function automatic logic [7:0] stat_compose(input logic [7:0] user_bits, input logic latch);
        logic [7:0] v;
        v = user_bits & STAT_USER_MASK;
        v[STAT_LATCH_POS] = latch;
        return v;
    endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
    import spi_mem_pkg::*;
#(
    parameter int unsigned STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     sck,
    input  logic     cs_n,
    input  logic     mosi,
    output pin_evt_t evt
);
    localparam int unsigned NSTG = (STAGES < 2) ? 2 : STAGES;

    // each stage carries {sck, cs_n, mosi}
    logic [NSTG-1:0][2:0] chain_q;
    logic                 sck_d_q;
    logic                 csn_d_q;
    logic                 sck_s, csn_s, mosi_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(NSTG); i++) chain_q[i] <= 3'b010;
            sck_d_q <= 1'b0;
            csn_d_q <= 1'b1;
        end else begin
            chain_q[0] <= {sck, cs_n, mosi};
            for (int i = 1; i < int'(NSTG); i++) chain_q[i] <= chain_q[i-1];
            sck_d_q <= sck_s;
            csn_d_q <= csn_s;
        end
    end

    assign {sck_s, csn_s, mosi_s} = chain_q[NSTG-1];

    always_comb begin
        evt.selected = ~csn_s;
        evt.released = csn_s & ~csn_d_q;
        evt.sck_rise = sck_s & ~sck_d_q & ~csn_s;
        evt.sck_fall = ~sck_s & sck_d_q & ~csn_s;
        evt.mosi     = mosi_s;
    end

endmodule

// File: rtl/spi_byte_io.sv
module spi_byte_io
    import spi_mem_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       sck_rise,
    input  logic       sck_fall,
    input  logic       selected,
    input  logic       mosi,
    input  logic [7:0] tx_next,
    output rx_byte_t   rx,
    output logic       miso
);
    logic [2:0] bit_cnt_q;
    logic [6:0] rx_sh_q;
    logic [6:0] tx_sh_q;
    logic       miso_q;

    always_ff @(posedge clk) begin
        if (rst || !selected) begin
            bit_cnt_q <= '0;
            rx_sh_q   <= '0;
            tx_sh_q   <= '0;
            miso_q    <= 1'b0;
        end else begin
            if (sck_rise) begin
                rx_sh_q   <= {rx_sh_q[5:0], mosi};
                bit_cnt_q <= bit_cnt_q + 3'd1;
            end
            if (sck_fall) begin
                if (bit_cnt_q == 3'd0) begin
                    miso_q  <= tx_next[7];
                    tx_sh_q <= tx_next[6:0];
                end else begin
                    miso_q  <= tx_sh_q[6];
                    tx_sh_q <= {tx_sh_q[5:0], 1'b0};
                end
            end
        end
    end

    always_comb begin
        rx.valid = sck_rise && (bit_cnt_q == 3'd7);
        rx.data  = {rx_sh_q, mosi};
    end

    assign miso = miso_q;

    // R8: a completed byte always leaves the bit counter on a byte boundary
    p_byte_boundary_r8: assert property (@(posedge clk) disable iff (rst)
        rx.valid |=> (bit_cnt_q == 3'd0));

endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
    import spi_mem_pkg::*;
#(
    parameter int unsigned ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              selected,
    input  logic              released,
    input  rx_byte_t          rx,
    output logic [7:0]        tx_next,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int unsigned HI_BITS = ADDR_W - 8;

    phase_e            phase_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        addr_hi_q;
    logic              put_q;
    logic              latch_q;
    logic [7:0]        user_q;
    logic              wrote_q;
    logic [7:0]        status;

    assign status = stat_compose(user_q, latch_q);

    always_comb begin
        case (phase_q)
            PH_STAT_GET: tx_next = status;
            PH_MEM_GET:  tx_next = mem_rdata;
            default:     tx_next = 8'h00;
        endcase
    end

    assign mem_we    = rx.valid && (phase_q == PH_MEM_PUT);
    assign mem_addr  = addr_q;
    assign mem_wdata = rx.data;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_OPCODE;
            addr_q    <= '0;
            addr_hi_q <= '0;
            put_q     <= 1'b0;
            latch_q   <= 1'b0;
            user_q    <= '0;
            wrote_q   <= 1'b0;
        end else if (!selected) begin
            phase_q <= PH_OPCODE;
            wrote_q <= 1'b0;
            if (released && wrote_q) latch_q <= 1'b0;
        end else if (rx.valid) begin
            case (phase_q)
                PH_OPCODE: begin
                    case (rx.data)
                        CMD_LATCH_ON: begin
                            latch_q <= 1'b1;
                            phase_q <= PH_DISCARD;
                        end
                        CMD_LATCH_OFF: begin
                            latch_q <= 1'b0;
                            phase_q <= PH_DISCARD;
                        end
                        CMD_STAT_GET: phase_q <= PH_STAT_GET;
                        CMD_STAT_PUT: phase_q <= latch_q ? PH_STAT_PUT : PH_DISCARD;
                        CMD_MEM_GET: begin
                            put_q   <= 1'b0;
                            phase_q <= PH_ADDR_HI;
                        end
                        CMD_MEM_PUT: begin
                            put_q   <= 1'b1;
                            phase_q <= latch_q ? PH_ADDR_HI : PH_DISCARD;
                        end
                        default: phase_q <= PH_DISCARD;
                    endcase
                end
                PH_ADDR_HI: begin
                    addr_hi_q <= rx.data;
                    phase_q   <= PH_ADDR_LO;
                end
                PH_ADDR_LO: begin
                    addr_q  <= {addr_hi_q[HI_BITS-1:0], rx.data};
                    phase_q <= put_q ? PH_MEM_PUT : PH_MEM_GET;
                end
                PH_MEM_GET: addr_q <= addr_q + 1'b1;
                PH_MEM_PUT: begin
                    addr_q  <= addr_q + 1'b1;
                    wrote_q <= 1'b1;
                end
                PH_STAT_PUT: begin
                    user_q  <= rx.data & STAT_USER_MASK;
                    wrote_q <= 1'b1;
                    phase_q <= PH_DISCARD;
                end
                default: ;
            endcase
        end
    end

    // R2: the latch only rises on a set-enable opcode
    p_latch_set_cause_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(latch_q) |-> $past(rx.valid && phase_q == PH_OPCODE && rx.data == CMD_LATCH_ON));

    // R3 / R6: the latch only falls on the disable opcode or at the end of a write
    p_latch_clear_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(latch_q) |-> $past((rx.valid && phase_q == PH_OPCODE && rx.data == CMD_LATCH_OFF)
                                 || (released && wrote_q)));

    // R7: no array write without the latch
    p_mem_write_gated_r7: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> latch_q);

    // R5: status user bits only change while the latch was set
    p_stat_change_gated_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(user_q) |-> $past(latch_q));

    // R8: pointer wraps to zero at the top of the array
    p_addr_wrap_r8: assert property (@(posedge clk) disable iff (rst)
        (selected && rx.valid && (phase_q == PH_MEM_GET || phase_q == PH_MEM_PUT) && addr_q == '1)
        |=> (addr_q == '0));

endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave
    import spi_mem_pkg::*;
#(
    parameter int unsigned ADDR_W      = 11,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso
);
    pin_evt_t          evt;
    rx_byte_t          rx;
    logic [7:0]        tx_next;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;

    spi_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .sck  (spi_sck),
        .cs_n (spi_cs_n),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    spi_byte_io io_i (
        .clk      (clk),
        .rst      (rst),
        .sck_rise (evt.sck_rise),
        .sck_fall (evt.sck_fall),
        .selected (evt.selected),
        .mosi     (evt.mosi),
        .tx_next  (tx_next),
        .rx       (rx),
        .miso     (spi_miso)
    );

    spi_cmd_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .selected  (evt.selected),
        .released  (evt.released),
        .rx        (rx),
        .tx_next   (tx_next),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    spi_mem_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) array_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (mem_addr),
        .rdata (mem_rdata)
    );

    // R1: serial output stays low whenever chip select is high
    p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        (!evt.selected && $past(!evt.selected)) |-> (spi_miso == 1'b0));

endmodule

// File: tb/spi_mem_slave_tb_top.sv
`timescale 1ns/1ps
module spi_mem_slave_tb_top;

    localparam int HALF  = 8;
    localparam int DEPTH = 2048;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [7:0] model [DEPTH];

    always #10 clk = ~clk;

    spi_mem_slave dut_i (
        .clk      (clk),
        .rst      (rst),
        .spi_cs_n (cs_n),
        .spi_sck  (sck),
        .spi_mosi (mosi),
        .spi_miso (miso)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sel();
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic desel();
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(3 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rxb);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            wait_clk(HALF);
            rxb[i] = miso;
            sck = 1'b1;
            wait_clk(HALF);
            sck = 1'b0;
        end
    endtask

    task automatic cmd1(input logic [7:0] op);
        logic [7:0] d;
        sel();
        xfer(op, d);
        desel();
    endtask

    task automatic get_stat(output logic [7:0] s);
        logic [7:0] d;
        sel();
        xfer(8'h05, d);
        xfer(8'h00, s);
        desel();
    endtask

    task automatic put_stat(input logic [7:0] v);
        logic [7:0] d;
        sel();
        xfer(8'h01, d);
        xfer(v, d);
        desel();
    endtask

    function automatic logic [7:0] pat(input int a, input int seed);
        return 8'((a * 7 + seed * 13 + 5) & 8'hFF);
    endfunction

    task automatic mem_put(input logic [15:0] a, input int n, input int seed, input bit update);
        logic [7:0] d;
        sel();
        xfer(8'h02, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = (int'(a[10:0]) + k) % DEPTH;
            xfer(pat(idx, seed), d);
            if (update) model[idx] = pat(idx, seed);
        end
        desel();
    endtask

    task automatic mem_check(input string req, input logic [15:0] a, input int n);
        logic [7:0] d;
        sel();
        xfer(8'h03, d);
        xfer(a[15:8], d);
        xfer(a[7:0], d);
        for (int k = 0; k < n; k++) begin
            int idx;
            idx = (int'(a[10:0]) + k) % DEPTH;
            xfer(8'h00, d);
            chk(req, d, model[idx]);
        end
        desel();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] s;
        logic [7:0] d;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'h00;

        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R1: reset state
        chk("R1 miso idle", {7'd0, miso}, 8'h00);
        get_stat(s);
        chk("R1 status after reset", s, 8'h00);
        chk("R1 miso after command", {7'd0, miso}, 8'h00);

        // R2 / R3
        cmd1(8'h06);
        get_stat(s);
        chk("R2 latch set", s, 8'h02);
        cmd1(8'h04);
        get_stat(s);
        chk("R3 latch cleared", s, 8'h00);

        // R5: status write with latch clear
        put_stat(8'hFF);
        get_stat(s);
        chk("R5 status write refused", s, 8'h00);

        // R4: sweep of status values
        for (int v = 0; v < 256; v += 17) begin
            cmd1(8'h06);
            put_stat(8'(v));
            get_stat(s);
            chk("R4 status masked and latch cleared", s, 8'(v) & 8'h8C);
        end
        cmd1(8'h06);
        put_stat(8'h8C);
        put_stat(8'h00);
        get_stat(s);
        chk("R5 second write without latch", s, 8'h8C);
        cmd1(8'h06);
        put_stat(8'h00);

        // R12: repeated status and extra bytes after single-byte commands
        sel();
        xfer(8'h06, d);
        xfer(8'h04, d);
        desel();
        sel();
        xfer(8'h05, d);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h00, s);
            chk("R12 status repeat / extra byte ignored", s, 8'h02);
        end
        desel();

        // R10: unknown opcode with latch set
        sel();
        xfer(8'hA5, d);
        for (int k = 0; k < 3; k++) begin
            xfer(8'h06 + 8'(k), d);
            chk("R10 miso low on unknown", d, 8'h00);
        end
        desel();
        get_stat(s);
        chk("R10 latch kept", s, 8'h02);

        // R11: write with address only keeps latch
        sel();
        xfer(8'h02, d);
        xfer(8'h01, d);
        xfer(8'h23, d);
        desel();
        get_stat(s);
        chk("R11 latch kept without data", s, 8'h02);

        // R6 / R8: block writes at several starts, including the wrap
        for (int b = 0; b < 8; b++) begin
            cmd1(8'h06);
            mem_put(16'(b * 256 + b * 3), 20, b, 1'b1);
            get_stat(s);
            chk("R6 latch cleared after write", s, 8'h00);
        end
        cmd1(8'h06);
        mem_put(16'h07F4, 24, 9, 1'b1);
        for (int b = 0; b < 8; b++) mem_check("R8 read back", 16'(b * 256 + b * 3), 20);
        mem_check("R8 wrap 7FF to 000", 16'h07F4, 24);

        // R9: upper address bits ignored on read and write
        mem_check("R9 upper bits on read", 16'hF800 | 16'h0103, 8);
        cmd1(8'h06);
        mem_put(16'hA000 | 16'h0400, 6, 21, 1'b1);
        mem_check("R9 upper bits on write", 16'h0400, 6);

        // R7: write without latch is ignored
        mem_put(16'h0103, 8, 33, 1'b0);
        mem_check("R7 memory unchanged", 16'h0103, 8);

        chk("R1 miso idle at end", {7'd0, miso}, 8'h00);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule